// File: doc/BRIEF.md
# Parallel von Neumann de-biasing filter

This block takes raw words from two coupled detector arrays, joins them into one wide word, and removes bias with the von Neumann rule. A full joined word goes through the filter in each cycle. Every non-overlapping pair of adjacent bits yields either one output bit or none. The number of surviving bits changes from word to word. A tree of merge stages packs them densely, and a residue buffer collects them. The buffer hands out fixed-width output words whenever enough bits are present.

Two saturating counters record how many raw bits were taken in and how many de-biased bits were kept. The retained-to-raw ratio follows from these two counts. At the best operating point this ratio is about one quarter. The output side applies backpressure through a ready signal. The input ready signal drops early enough that the buffer can never be overrun by words already inside the pipeline.

Top module: `vn_debias_top`

## Requirements
- R1: The filtered word is `{b_data_i, a_data_i}`, with lane A in the low bits. Pair i is formed from bit 2i (the first bit) and bit 2i+1 (the second bit). First=1 with second=0 yields a 1. First=0 with second=1 yields a 0. A pair of two equal bits yields nothing.
- R2: Surviving bits keep their order. Within a word they are ordered by ascending pair index, and words follow in acceptance order. Output bit 0 holds the earliest bit. `out_valid_o` is high exactly when at least OUT_W bits are buffered. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value.
- R3: `in_ready_o` is low whenever the buffered bits, plus PAIRS bits for each word still in the pipeline, plus PAIRS more, would exceed BUF_W = 4*PAIRS. Starting from empty with `out_ready_i` low, exactly four words with all pairs surviving are accepted.
- R4: A word is accepted only in a cycle where `a_valid_i`, `b_valid_i` and `in_ready_o` are all high. Each accepted word adds 2*LANE_W to `raw_cnt_o`. If only one lane is valid, nothing is taken.
- R5: `kept_cnt_o` grows by the number of surviving bits of each word. Both counters stop at 2^CNT_W-1 instead of wrapping.
- R6: The survivors of a word accepted at clock edge k become visible at `out_valid_o` and `kept_cnt_o` right after edge k+2.
- R7: After reset, `in_ready_o` is 1, `out_valid_o` is 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | LANE_W | Raw word from the first array (low half) |
| a_valid_i | input | 1 | First array word valid |
| b_data_i | input | LANE_W | Raw word from the second array (high half) |
| b_valid_i | input | 1 | Second array word valid |
| in_ready_o | output | 1 | Filter can accept a joined word |
| out_data_o | output | OUT_W | Packed de-biased bits, oldest in bit 0 |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Consumer takes the output word |
| raw_cnt_o | output | CNT_W | Saturating count of raw bits accepted |
| kept_cnt_o | output | CNT_W | Saturating count of bits retained |

## Verification
The assertions check four things on every cycle: the residue fill never passes its capacity, the input is refused once the fill passes its limit, a stalled output word stays unchanged, and the raw count never moves without an accepted word. They also check that the counters never go backwards and that the kept count grows by at most one word's pairs. The bench scenarios cover the rest: that each pair gives the right bit in the right place across word boundaries, the exact three-edge latency, the exact number of words accepted before backpressure, and saturation of the counters. Saturation is checked on a second, narrow instance, whose counters can reach their ceiling in a short run.

// File: rtl/vnd_pkg.sv
package vnd_pkg;
  localparam int unsigned DEF_LANE_W = 128;
  localparam int unsigned DEF_OUT_W  = 64;
  localparam int unsigned DEF_CNT_W  = 48;
endpackage

// File: rtl/vn_pair_dec.sv
module vn_pair_dec #(
  parameter int unsigned PAIRS = 128
) (
  input  logic [2*PAIRS-1:0] raw_i,
  output logic [PAIRS-1:0]   keep_o,
  output logic [PAIRS-1:0]   val_o
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign keep_o[i] = raw_i[2*i] ^ raw_i[2*i+1];
    assign val_o[i]  = raw_i[2*i];  // first bit of a differing pair
  end
endmodule

// File: rtl/vn_compact.sv
module vn_compact #(
  parameter int unsigned N    = 128,
  localparam int unsigned LOGN = $clog2(N)
) (
  input  logic [N-1:0]  keep_i,
  input  logic [N-1:0]  val_i,
  output logic [N-1:0]  packed_o,
  output logic [LOGN:0] cnt_o
);
  // merge tree: each level joins neighbour groups, upper group shifted by lower count
  for (genvar l = 0; l <= LOGN; l++) begin : g_lvl
    logic [N-1:0] d;
    logic [LOGN:0] c [N>>l];
    if (l == 0) begin : g_leaf
      assign d = val_i & keep_i;
      for (genvar i = 0; i < N; i++) begin : g_c
        assign c[i] = {{LOGN{1'b0}}, keep_i[i]};
      end
    end else begin : g_merge
      localparam int unsigned G = 1 << (l - 1);
      for (genvar g = 0; g < (N >> l); g++) begin : g_grp
        assign d[2*G*g +: 2*G] = {{G{1'b0}}, g_lvl[l-1].d[2*G*g +: G]}
                               | ({{G{1'b0}}, g_lvl[l-1].d[2*G*g+G +: G]} << g_lvl[l-1].c[2*g]);
        assign c[g] = g_lvl[l-1].c[2*g] + g_lvl[l-1].c[2*g+1];
      end
    end
  end

  assign packed_o = g_lvl[LOGN].d;
  assign cnt_o    = g_lvl[LOGN].c[0];
endmodule

// File: rtl/vn_residue.sv
module vn_residue #(
  parameter int unsigned PAIRS  = 128,
  parameter int unsigned OUT_W  = 64,
  parameter int unsigned BUF_W  = 4*PAIRS,
  localparam int unsigned FILL_W = $clog2(BUF_W+1),
  localparam int unsigned PCNT_W = $clog2(PAIRS)+1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_v_i,
  input  logic [PAIRS-1:0]  in_data_i,
  input  logic [PCNT_W-1:0] in_cnt_i,
  input  logic              pop_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              valid_o,
  output logic [FILL_W-1:0] fill_o
);
  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [FILL_W-1:0] fill_q, fill_d, pop_amt, base, add;

  assign valid_o = fill_q >= FILL_W'(OUT_W);
  assign data_o  = buf_q[OUT_W-1:0];
  assign fill_o  = fill_q;

  always_comb begin
    pop_amt = (pop_i && valid_o) ? FILL_W'(OUT_W) : '0;
    base    = fill_q - pop_amt;
    add     = in_v_i ? FILL_W'(in_cnt_i) : '0;
    fill_d  = base + add;
    buf_d   = buf_q >> pop_amt;
    if (in_v_i) buf_d = buf_d | ({{(BUF_W-PAIRS){1'b0}}, in_data_i} << base);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else begin
      buf_q  <= buf_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/vn_sat_cnt.sv
module vn_sat_cnt #(
  parameter int unsigned W     = 48,
  parameter int unsigned INC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W:0] sum;
  assign sum = {1'b0, cnt_o} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (en_i)   cnt_o <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/vn_debias_top.sv
module vn_debias_top
  import vnd_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned RAW_W  = 2*LANE_W,
  localparam int unsigned PAIRS  = LANE_W,
  localparam int unsigned BUF_W  = 4*PAIRS,
  localparam int unsigned FILL_W = $clog2(BUF_W+1),
  localparam int unsigned PCNT_W = $clog2(PAIRS)+1,
  localparam int unsigned RINC_W = $clog2(RAW_W+1),
  localparam int unsigned NEED_W = FILL_W+2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] a_data_i,
  input  logic              a_valid_i,
  input  logic [LANE_W-1:0] b_data_i,
  input  logic              b_valid_i,
  output logic              in_ready_o,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CNT_W-1:0]  raw_cnt_o,
  output logic [CNT_W-1:0]  kept_cnt_o
);
  logic              fire;
  logic [PAIRS-1:0]  dec_keep, dec_val, keep_q, val_q, cmp_data, pk_q;
  logic [PCNT_W-1:0] cmp_cnt, pk_cnt_q;
  logic              s1_v, s2_v;
  logic [FILL_W-1:0] res_fill;
  logic [NEED_W-1:0] need;

  assign fire = a_valid_i && b_valid_i && in_ready_o;

  // credit counts words in flight as full, pops are ignored
  always_comb begin
    need = NEED_W'(res_fill) + NEED_W'(PAIRS);
    if (s1_v) need = need + NEED_W'(PAIRS);
    if (s2_v) need = need + NEED_W'(PAIRS);
  end
  assign in_ready_o = need <= NEED_W'(BUF_W);

  vn_pair_dec #(.PAIRS(PAIRS)) u_dec (
    .raw_i  ({b_data_i, a_data_i}),
    .keep_o (dec_keep),
    .val_o  (dec_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      keep_q <= '0;
      val_q  <= '0;
    end else begin
      s1_v <= fire;
      if (fire) begin
        keep_q <= dec_keep;
        val_q  <= dec_val;
      end
    end
  end

  vn_compact #(.N(PAIRS)) u_cmp (
    .keep_i   (keep_q),
    .val_i    (val_q),
    .packed_o (cmp_data),
    .cnt_o    (cmp_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v     <= 1'b0;
      pk_q     <= '0;
      pk_cnt_q <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        pk_q     <= cmp_data;
        pk_cnt_q <= cmp_cnt;
      end
    end
  end

  vn_residue #(.PAIRS(PAIRS), .OUT_W(OUT_W), .BUF_W(BUF_W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_v_i    (s2_v),
    .in_data_i (pk_q),
    .in_cnt_i  (pk_cnt_q),
    .pop_i     (out_ready_i),
    .data_o    (out_data_o),
    .valid_o   (out_valid_o),
    .fill_o    (res_fill)
  );

  vn_sat_cnt #(.W(CNT_W), .INC_W(RINC_W)) u_raw_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fire),
    .inc_i  (RINC_W'(RAW_W)),
    .cnt_o  (raw_cnt_o)
  );

  vn_sat_cnt #(.W(CNT_W), .INC_W(PCNT_W)) u_kept_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (s2_v),
    .inc_i  (pk_cnt_q),
    .cnt_o  (kept_cnt_o)
  );
endmodule

// File: rtl/vn_debias_chk.sv
module vn_debias_chk #(
  parameter int unsigned PAIRS  = 128,
  parameter int unsigned OUT_W  = 64,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned BUF_W  = 512,
  parameter int unsigned FILL_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_valid_i,
  input logic              b_valid_i,
  input logic              in_ready_i,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic [OUT_W-1:0]  out_data_i,
  input logic [CNT_W-1:0]  raw_cnt_i,
  input logic [CNT_W-1:0]  kept_cnt_i,
  input logic [FILL_W-1:0] fill_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FILL_W'(BUF_W)); // R3
  AST_READY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i > FILL_W'(BUF_W - PAIRS)) |-> !in_ready_i); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i))); // R2
  AST_RAW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_valid_i && b_valid_i && in_ready_i) |=> $stable(raw_cnt_i)); // R4
  AST_RAW_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_cnt_i >= $past(raw_cnt_i)); // R5
  AST_KEPT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kept_cnt_i >= $past(kept_cnt_i)) && (kept_cnt_i - $past(kept_cnt_i) <= CNT_W'(PAIRS))); // R5
endmodule

bind vn_debias_top vn_debias_chk #(
  .PAIRS(PAIRS), .OUT_W(OUT_W), .CNT_W(CNT_W), .BUF_W(BUF_W), .FILL_W(FILL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_valid_i   (a_valid_i),
  .b_valid_i   (b_valid_i),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_i  (out_data_o),
  .raw_cnt_i   (raw_cnt_o),
  .kept_cnt_i  (kept_cnt_o),
  .fill_i      (res_fill)
);

// File: tb/vn_debias_top_tb.sv
module vn_debias_top_tb;
  localparam int LW = 128;
  localparam int OW = 64;
  localparam int CW = 48;
  localparam int SLW = 8;
  localparam int SOW = 8;
  localparam int SCW = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic [LW-1:0] a_data, b_data;
  logic a_valid, b_valid, out_ready;
  logic in_ready, out_valid;
  logic [OW-1:0] out_data;
  logic [CW-1:0] raw_cnt, kept_cnt;

  logic [SLW-1:0] sa_data, sb_data;
  logic sa_valid, sb_valid, s_out_ready, s_in_ready, s_out_valid;
  logic [SOW-1:0] s_out_data;
  logic [SCW-1:0] s_raw, s_kept;

  vn_debias_top #(.LANE_W(LW), .OUT_W(OW), .CNT_W(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_data_i(a_data), .a_valid_i(a_valid), .b_data_i(b_data), .b_valid_i(b_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .raw_cnt_o(raw_cnt), .kept_cnt_o(kept_cnt));

  vn_debias_top #(.LANE_W(SLW), .OUT_W(SOW), .CNT_W(SCW)) u_sat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_data_i(sa_data), .a_valid_i(sa_valid), .b_data_i(sb_data), .b_valid_i(sb_valid),
    .in_ready_o(s_in_ready), .out_data_o(s_out_data), .out_valid_o(s_out_valid),
    .out_ready_i(s_out_ready), .raw_cnt_o(s_raw), .kept_cnt_o(s_kept));

  int checks = 0;
  int errors = 0;
  bit q[$];
  longint acc = 0;
  longint kept_total = 0;
  int pops = 0;
  bit last_fire;
  bit done = 0;

  localparam logic [LW-1:0] ONES_PAT  = {(LW/2){2'b01}};
  localparam logic [LW-1:0] ZEROS_PAT = {(LW/2){2'b10}};

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // R1: bench model of the pair rule on {b,a}
  task automatic push_word(input logic [LW-1:0] a, input logic [LW-1:0] b);
    logic [2*LW-1:0] w;
    w = {b, a};
    for (int i = 0; i < LW; i++) begin
      if (w[2*i] != w[2*i+1]) begin
        q.push_back(w[2*i]);
        kept_total++;
      end
    end
  endtask

  task automatic pop_check(input logic [OW-1:0] got);
    logic [OW-1:0] exp;
    pops++;
    if (q.size() < OW) begin
      chk(0, "R2 output with too few model bits", 128'(got), 128'(q.size()));
      q.delete();
      return;
    end
    for (int j = 0; j < OW; j++) exp[j] = q.pop_front();
    chk(got == exp, "R1 R2 packed output word", 128'(got), 128'(exp));
  endtask

  task automatic step(input logic [LW-1:0] a, input logic [LW-1:0] b,
                      input logic va, input logic vb, input logic ordy);
    @(negedge clk_i);
    a_data = a; b_data = b; a_valid = va; b_valid = vb; out_ready = ordy;
    last_fire = va && vb && in_ready;
    if (last_fire) begin
      acc++;
      push_word(a, b);
    end
    if (out_valid && ordy) pop_check(out_data);
  endtask

  function automatic logic [LW-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n_acc;
    logic [CW-1:0] raw_before;
    longint s_acc;
    void'($urandom(32'd20240611));
    a_data = '0; b_data = '0; a_valid = 0; b_valid = 0; out_ready = 0;
    sa_data = '0; sb_data = '0; sa_valid = 0; sb_valid = 0; s_out_ready = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 reset state
    @(negedge clk_i);
    chk(in_ready == 1'b1, "R7 in_ready after reset", 128'(in_ready), 128'(1));
    chk(out_valid == 1'b0, "R7 out_valid after reset", 128'(out_valid), 128'(0));
    chk(raw_cnt == '0, "R7 raw count after reset", 128'(raw_cnt), 128'(0));
    chk(kept_cnt == '0, "R7 kept count after reset", 128'(kept_cnt), 128'(0));

    // R3 backpressure: all pairs survive, consumer stalled
    n_acc = 0;
    for (int i = 0; i < 20; i++) begin
      step(ONES_PAT, ONES_PAT, 1, 1, 0);
      if (last_fire) n_acc++;
    end
    chk(n_acc == 4, "R3 words accepted before stall", 128'(n_acc), 128'(4));
    chk(in_ready == 1'b0, "R3 in_ready low when full", 128'(in_ready), 128'(0));
    pops = 0;
    for (int i = 0; i < 12; i++) step('0, '0, 0, 0, 1);
    chk(pops == 8, "R3 words drained after stall", 128'(pops), 128'(8));

    // R6 latency and R1 single-lane ones
    step(ONES_PAT, '0, 1, 1, 0);
    chk(last_fire == 1'b1, "R6 word accepted", 128'(last_fire), 128'(1));
    step('0, '0, 0, 0, 0);
    chk(out_valid == 1'b0, "R6 not visible after first edge", 128'(out_valid), 128'(0));
    step('0, '0, 0, 0, 0);
    chk(out_valid == 1'b0, "R6 not visible after second edge", 128'(out_valid), 128'(0));
    step('0, '0, 0, 0, 0);
    chk(out_valid == 1'b1, "R6 visible after third edge", 128'(out_valid), 128'(1));
    chk(kept_cnt == CW'(kept_total), "R5 R6 kept count after latency", 128'(kept_cnt), 128'(kept_total));
    for (int i = 0; i < 4; i++) step('0, '0, 0, 0, 1);

    // R1 zeros pattern and discarded pairs mixed
    step(ZEROS_PAT, '0, 1, 1, 1);
    step({LW{1'b1}}, ZEROS_PAT, 1, 1, 1);
    for (int i = 0; i < 8; i++) step('0, '0, 0, 0, 1);
    chk(q.size() == 0, "R2 all bits emitted from full words", 128'(q.size()), 128'(0));

    // R4 single lane valid is ignored
    raw_before = raw_cnt;
    step(ONES_PAT, ONES_PAT, 1, 0, 1);
    step(ONES_PAT, ONES_PAT, 0, 1, 1);
    for (int i = 0; i < 4; i++) step('0, '0, 0, 0, 1);
    chk(raw_cnt == raw_before, "R4 raw unchanged on one-lane valid", 128'(raw_cnt), 128'(raw_before));
    chk(out_valid == 1'b0, "R4 nothing buffered on one-lane valid", 128'(out_valid), 128'(0));
    chk(kept_cnt == CW'(kept_total), "R4 kept unchanged on one-lane valid", 128'(kept_cnt), 128'(kept_total));

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [LW-1:0] ra, rb;
      ra = rnd_word();
      rb = rnd_word();
      if (($urandom % 8) == 0) rb = ONES_PAT;
      step(ra, rb, ($urandom % 100) < 85, ($urandom % 100) < 85, ($urandom % 100) < 75);
    end
    for (int i = 0; i < 30; i++) step('0, '0, 0, 0, 1);
    chk(raw_cnt == CW'(acc * 2 * LW), "R4 raw count total", 128'(raw_cnt), 128'(acc * 2 * LW));
    chk(kept_cnt == CW'(kept_total), "R5 kept count total", 128'(kept_cnt), 128'(kept_total));
    chk(q.size() < OW, "R2 residue below one word", 128'(q.size()), 128'(OW));
    chk(out_valid == 1'b0, "R2 out_valid low below one word", 128'(out_valid), 128'(0));

    // R5 saturation on the narrow instance
    s_acc = 0;
    for (int i = 0; i < 320; i++) begin
      @(negedge clk_i);
      sa_data = {(SLW/2){2'b01}}; sb_data = {(SLW/2){2'b10}};
      sa_valid = 1; sb_valid = 1; s_out_ready = 1;
      if (s_in_ready) s_acc++;
    end
    @(negedge clk_i);
    sa_valid = 0; sb_valid = 0;
    repeat (5) @(negedge clk_i);
    chk(s_acc >= 256, "R5 enough narrow words taken", 128'(s_acc), 128'(256));
    chk(s_raw == {SCW{1'b1}}, "R5 raw count saturates", 128'(s_raw), 128'({SCW{1'b1}}));
    chk(s_kept == {SCW{1'b1}}, "R5 kept count saturates", 128'(s_kept), 128'({SCW{1'b1}}));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule